// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a 32-bit processor that completes one instruction per clock. In one cycle it fetches a word from a small instruction store, decodes it, reads two source registers, computes the result, and then on the rising edge commits both the register write and the next program counter. It executes a thirteen-instruction integer subset: register arithmetic and logic, immediate arithmetic, an unsigned compare against an immediate, upper-immediate load, arithmetic right shifts by a constant or by a register amount, and two conditional branches. It has no data memory, jumps or exceptions.

The instruction store is filled through a valid/ready load port while the core is held in reset. When `prog_valid` and `prog_ready` are both high at a rising edge, the word on `prog_data` is written at word index `prog_addr`. `prog_ready` is high only while `rst_n` is low. Any beat offered while the core runs sees `prog_ready` low and is dropped. The source does not need to hold the beat, because ready stays low until the next reset. Every cycle the core reports its program counter and the register write the current instruction makes. A third read port (`dbg_idx`/`dbg_data`) shows any register asynchronously.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the program counter is 0 from the next edge on and `prog_ready` is 1. A word is stored only when `prog_valid` and `prog_ready` are both high, so load beats offered while running have no effect.
- R2: Opcode 0 with function 0x21, 0x23, 0x24, 0x25 or 0x2A performs add, subtract, AND, OR or signed set-less-than (result 1 or 0) on registers rs and rt, and writes to rd (bits 15:11).
- R3: Opcode 0x08 adds the sign-extended 16-bit immediate to rs. Opcode 0x0B sets 1 when rs is unsigned-less-than the sign-extended immediate (0xFFFF becomes 0xFFFFFFFF), otherwise 0. Both write rt (bits 20:16).
- R4: Opcode 0x0D ORs rs with the zero-extended immediate. Opcode 0x0F writes the immediate into bits 31:16 and zeros into bits 15:0. Both write rt.
- R5: Opcode 0 with function 0x03 shifts rt right arithmetically by the shamt field (bits 10:6) and ignores rs. Function 0x07 shifts rt right arithmetically by rs[4:0]. Both write rd.
- R6: Opcode 0x04 is taken when rs equals rt, and 0x05 when they differ. A taken branch sets PC = PC+4 + (sign-extended offset << 2). Branches never write a register.
- R7: Register 0 always reads as zero, on the datapath and on the debug port, and writes to it are discarded.
- R8: Out of reset, a non-branch or untaken branch advances the PC by 4. The instruction fetched is the stored word at index PC[7:2], which wraps over 64 words.
- R9: `wb_we`, `wb_idx` and `wb_data` show the write of the instruction at `pc_o` in the same cycle. Any other opcode or function code gives `wb_we` = 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset, also enables loading |
| prog_valid | input | 1 | Load beat offered |
| prog_ready | output | 1 | Load beat accepted (high only in reset) |
| prog_addr | input | 6 | Word index of the load beat |
| prog_data | input | 32 | Instruction word of the load beat |
| dbg_idx | input | 5 | Register selected for inspection |
| dbg_data | output | 32 | Contents of the selected register |
| pc_o | output | 32 | Byte address of the current instruction |
| wb_we | output | 1 | Current instruction writes a register |
| wb_idx | output | 5 | Destination register of the current instruction |
| wb_data | output | 32 | Value written at the next edge |

## Verification
Two activities can fall in the same cycle. The first is an instruction that both reads and targets register 0, which tests the read-as-zero rule against the discarded write. The second is a load beat offered while the core is running, which must be dropped while fetch reads the same store. Random programs over registers 0 to 7 produce dense read-after-write chains, frequent r0 targets and back-to-back branches. In half of the runs the load port is driven with random beats throughout. A bench-side instruction model predicts every cycle's PC and write, so a load beat that gets through, or a write to r0 that sticks, shows up as a miscompare on a later instruction. Three directed programs end with debug-port checks of final register values, including the shift loop that must leave -40.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int SH_W   = $clog2(XLEN);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTIU = 6'h0B;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LUI   = 6'h0F;

  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLTU, ALU_SRA, ALU_LUI
  } alu_op_e;

  // first-level class handed from the main decoder to the ALU decoder
  typedef enum logic [2:0] {
    CLS_FUNCT, CLS_ADD, CLS_SUB, CLS_SLTU, CLS_OR, CLS_LUI
  } alu_cls_e;

  typedef struct packed {
    logic     reg_we;
    logic     dst_rd;
    logic     use_imm;
    logic     imm_zext;
    logic     branch;
    logic     br_ne;
    alu_cls_e cls;
  } main_ctl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output main_ctl_t  ctl
);
  always_comb begin
    ctl = '{reg_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, imm_zext: 1'b0,
            branch: 1'b0, br_ne: 1'b0, cls: CLS_ADD};
    unique case (opcode)
      OP_RTYPE: begin ctl.reg_we = 1'b1; ctl.dst_rd = 1'b1; ctl.cls = CLS_FUNCT; end
      OP_ADDI:  begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.cls = CLS_ADD; end
      OP_SLTIU: begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.cls = CLS_SLTU; end
      OP_ORI:   begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.imm_zext = 1'b1; ctl.cls = CLS_OR; end
      OP_LUI:   begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.cls = CLS_LUI; end
      OP_BEQ:   begin ctl.branch = 1'b1; ctl.cls = CLS_SUB; end
      OP_BNE:   begin ctl.branch = 1'b1; ctl.br_ne = 1'b1; ctl.cls = CLS_SUB; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  alu_cls_e   cls,
  input  logic [5:0] funct,
  output alu_op_e    op,
  output logic       shamt_var,
  output logic       op_ok
);
  always_comb begin
    op        = ALU_ADD;
    shamt_var = 1'b0;
    op_ok     = 1'b1;
    unique case (cls)
      CLS_ADD:  op = ALU_ADD;
      CLS_SUB:  op = ALU_SUB;
      CLS_SLTU: op = ALU_SLTU;
      CLS_OR:   op = ALU_OR;
      CLS_LUI:  op = ALU_LUI;
      default: begin
        unique case (funct)
          FN_ADDU: op = ALU_ADD;
          FN_SUBU: op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          FN_SRA:  op = ALU_SRA;
          FN_SRAV: begin op = ALU_SRA; shamt_var = 1'b1; end
          default: op_ok = 1'b0;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e                op,
  input  logic [W-1:0]           a,
  input  logic [W-1:0]           b,
  input  logic [$clog2(W)-1:0]   sh,
  output logic [W-1:0]           y,
  output logic                   eq
);
  localparam int HALF = W / 2;

  assign eq = (a == b);

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_SLT:  y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: y = {{(W-1){1'b0}}, a < b};
      ALU_SRA:  y = W'($signed(b) >>> sh);
      default:  y = {b[HALF-1:0], {HALF{1'b0}}};
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  localparam int N = 1 << AW;

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we && wa != '0) begin
      mem[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : mem[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : mem[ra_b];
  assign rd_c = (ra_c == '0) ? '0 : mem[ra_c];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_valid,
  output logic               prog_ready,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [XLEN-1:0]    prog_data,
  input  logic [RIDX_W-1:0]  dbg_idx,
  output logic [XLEN-1:0]    dbg_data,
  output logic [XLEN-1:0]    pc_o,
  output logic               wb_we,
  output logic [RIDX_W-1:0]  wb_idx,
  output logic [XLEN-1:0]    wb_data
);
  localparam int IMEM_DEPTH = 1 << IMEM_AW;
  localparam int IMM_W      = 16;

  // instruction store, written only while held in reset
  logic [XLEN-1:0] imem [IMEM_DEPTH];
  assign prog_ready = !rst_n;

  always_ff @(posedge clk) begin
    if (prog_valid && prog_ready) imem[prog_addr] <= prog_data;
  end

  logic [XLEN-1:0] pc_q, pc_next, instr;
  assign instr = imem[pc_q[IMEM_AW+1:2]];
  assign pc_o  = pc_q;

  logic [5:0]        opcode, funct;
  logic [4:0]        f_rs, f_rt, f_rd;
  logic [SH_W-1:0]   f_shamt;
  logic [IMM_W-1:0]  f_imm;
  assign opcode  = instr[31:26];
  assign f_rs    = instr[25:21];
  assign f_rt    = instr[20:16];
  assign f_rd    = instr[15:11];
  assign f_shamt = instr[10:6];
  assign funct   = instr[5:0];
  assign f_imm   = instr[15:0];

  main_ctl_t mctl;
  alu_op_e   alu_op;
  logic      shamt_var, op_ok;

  sc_main_dec u_mdec (.opcode(opcode), .ctl(mctl));
  sc_alu_dec  u_adec (.cls(mctl.cls), .funct(funct), .op(alu_op),
                      .shamt_var(shamt_var), .op_ok(op_ok));

  logic [XLEN-1:0] rs_val, rt_val;

  sc_regfile #(.W(XLEN), .AW(RIDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(f_rs), .ra_b(f_rt), .ra_c(dbg_idx),
    .rd_a(rs_val), .rd_b(rt_val), .rd_c(dbg_data),
    .we(wb_we), .wa(wb_idx), .wd(wb_data)
  );

  logic [XLEN-1:0] imm_ext, alu_b, alu_y;
  logic [SH_W-1:0] sh_amt;
  logic            alu_eq;

  assign imm_ext = mctl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, f_imm}
                                 : {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
  assign alu_b   = mctl.use_imm ? imm_ext : rt_val;
  assign sh_amt  = shamt_var ? rs_val[SH_W-1:0] : f_shamt;

  sc_alu #(.W(XLEN)) u_alu (
    .op(alu_op), .a(rs_val), .b(alu_b), .sh(sh_amt), .y(alu_y), .eq(alu_eq)
  );

  assign wb_we   = mctl.reg_we && op_ok;
  assign wb_idx  = mctl.dst_rd ? f_rd : f_rt;
  assign wb_data = alu_y;

  // branch resolution
  logic            br_take;
  logic [XLEN-1:0] br_off, pc_plus4;
  assign br_take  = mctl.branch && (alu_eq ^ mctl.br_ne);
  assign br_off   = {{(XLEN-IMM_W-2){f_imm[IMM_W-1]}}, f_imm, 2'b00};
  assign pc_plus4 = pc_q + XLEN'(4);
  assign pc_next  = br_take ? pc_plus4 + br_off : pc_plus4;

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc_o,
  input logic              wb_we,
  input logic [RIDX_W-1:0] wb_idx,
  input logic [XLEN-1:0]   wb_data,
  input logic [RIDX_W-1:0] dbg_idx,
  input logic [XLEN-1:0]   dbg_data,
  input logic              br_take,
  input logic              is_branch,
  input logic [5:0]        opcode,
  input logic [XLEN-1:0]   br_off
);
  AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> pc_o == '0); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !br_take |=> pc_o == $past(pc_o) + XLEN'(4)); // R8
  AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> pc_o == $past(pc_o) + XLEN'(4) + $past(br_off)); // R6
  AST_BR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> !wb_we); // R6
  AST_LUI_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && opcode == OP_LUI) |-> wb_data[15:0] == '0); // R4
  AST_SLTIU_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && opcode == OP_SLTIU) |-> wb_data[XLEN-1:1] == '0); // R3
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_idx == '0) |-> dbg_data == '0); // R7
  AST_WB_IDX_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> !$isunknown(wb_idx)); // R9
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .wb_we(wb_we), .wb_idx(wb_idx),
  .wb_data(wb_data), .dbg_idx(dbg_idx), .dbg_data(dbg_data),
  .br_take(br_take), .is_branch(mctl.branch), .opcode(opcode), .br_off(br_off)
);

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_valid = 1'b0;
  logic        prog_ready;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [4:0]  dbg_idx = '0;
  logic [31:0] dbg_data, pc_o, wb_data;
  logic        wb_we;
  logic [4:0]  wb_idx;

  always #10 clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst_n(rst_n), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data), .dbg_idx(dbg_idx),
    .dbg_data(dbg_data), .pc_o(pc_o), .wb_we(wb_we), .wb_idx(wb_idx),
    .wb_data(wb_data)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_mem [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_pc;
  bit junk_on = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, rt, rd, sh, fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(input int op, rs, rt, input logic [15:0] im);
    return {6'(op), 5'(rs), 5'(rt), im};
  endfunction

  function automatic logic [31:0] rnd_ins();
    int k = int'($urandom % 15);
    int a = int'($urandom % 8), b = int'($urandom % 8), c = int'($urandom % 8);
    logic [15:0] im;
    case ($urandom % 4)
      0: im = 16'hFFFF;
      1: im = 16'h8000;
      2: im = 16'($urandom % 8);
      default: im = 16'($urandom);
    endcase
    case (k)
      0: return enc_r(a, b, c, 0, 'h21);
      1: return enc_r(a, b, c, 0, 'h23);
      2: return enc_r(a, b, c, 0, 'h24);
      3: return enc_r(a, b, c, 0, 'h25);
      4: return enc_r(a, b, c, 0, 'h2A);
      5: return enc_r(a, b, c, int'($urandom % 32), 'h03);
      6: return enc_r(a, b, c, 0, 'h07);
      7: return enc_i('h08, a, b, im);
      8: return enc_i('h0B, a, b, im);
      9: return enc_i('h0D, a, b, im);
      10: return enc_i('h0F, a, b, im);
      11: return enc_i('h04, a, b, 16'($urandom % 7) - 16'd3);
      12: return enc_i('h05, a, b, 16'($urandom % 7) - 16'd3);
      13: return enc_r(a, b, c, 0, 'h00);
      default: return enc_i('h3F, a, b, im);
    endcase
  endfunction

  // reference model: compare this cycle's outputs, then advance
  task automatic step_check();
    logic [31:0] ins, rs_v, rt_v, sx, zx, val, npc;
    logic [4:0] idx;
    logic we;
    string rq;
    ins  = m_mem[m_pc[7:2]];
    rs_v = m_reg[ins[25:21]];
    rt_v = m_reg[ins[20:16]];
    sx   = {{16{ins[15]}}, ins[15:0]};
    zx   = {16'h0, ins[15:0]};
    npc  = m_pc + 32'd4;
    we = 1'b1; idx = ins[20:16]; val = '0; rq = "R9";
    case (ins[31:26])
      6'h00: begin
        idx = ins[15:11];
        case (ins[5:0])
          6'h21: begin val = rs_v + rt_v; rq = "R2"; end
          6'h23: begin val = rs_v - rt_v; rq = "R2"; end
          6'h24: begin val = rs_v & rt_v; rq = "R2"; end
          6'h25: begin val = rs_v | rt_v; rq = "R2"; end
          6'h2A: begin val = {31'h0, $signed(rs_v) < $signed(rt_v)}; rq = "R2"; end
          6'h03: begin val = $signed(rt_v) >>> ins[10:6]; rq = "R5"; end
          6'h07: begin val = $signed(rt_v) >>> rs_v[4:0]; rq = "R5"; end
          default: we = 1'b0;
        endcase
      end
      6'h08: begin val = rs_v + sx; rq = "R3"; end
      6'h0B: begin val = {31'h0, rs_v < sx}; rq = "R3"; end
      6'h0D: begin val = rs_v | zx; rq = "R4"; end
      6'h0F: begin val = {ins[15:0], 16'h0}; rq = "R4"; end
      6'h04, 6'h05: begin
        we = 1'b0; rq = "R6";
        if ((rs_v == rt_v) ^ ins[26]) npc = m_pc + 32'd4 + {sx[29:0], 2'b00};
      end
      default: we = 1'b0;
    endcase
    chk(pc_o == m_pc, "R8 pc", pc_o, m_pc);
    chk(wb_we == we, {rq, " we"}, 32'(wb_we), 32'(we));
    if (we) begin
      chk(wb_idx == idx, {rq, " idx"}, 32'(wb_idx), 32'(idx));
      chk(wb_data == val, {rq, " data"}, wb_data, val);
      if (idx != 0) m_reg[idx] = val;
    end
    m_pc = npc;
  endtask

  task automatic load_and_run(input int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pc_o == 0, "R1 reset pc", pc_o, 0);
    chk(prog_ready == 1'b1, "R1 ready in reset", 32'(prog_ready), 1);
    for (int i = 0; i < 64; i++) begin
      prog_valid = 1'b1; prog_addr = 6'(i); prog_data = m_mem[i];
      @(negedge clk);
    end
    prog_valid = 1'b0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    rst_n = 1'b1;
    #1;
    chk(prog_ready == 1'b0, "R1 ready when running", 32'(prog_ready), 0);
    for (int c = 0; c < cycles; c++) begin
      if (c != 0) begin @(negedge clk); #1; end
      if (junk_on) begin
        prog_valid = 1'b1; prog_addr = 6'($urandom); prog_data = $urandom;
      end
      step_check();
    end
    prog_valid = 1'b0;
  endtask

  task automatic dbg_chk(input int r, input logic [31:0] exp, input string rq);
    dbg_idx = 5'(r);
    #1;
    chk(dbg_data == exp, rq, dbg_data, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // program A: arithmetic, compare, branch, r0 write then read
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_mem[0] = enc_i('h08, 0, 1, 16'd13);
    m_mem[1] = enc_i('h08, 0, 2, 16'd7);
    m_mem[2] = enc_i('h0B, 1, 3, 16'hFFFF);
    m_mem[3] = enc_i('h04, 3, 0, 16'd1);
    m_mem[4] = enc_r(2, 1, 4, 0, 'h2A);
    m_mem[5] = enc_r(1, 4, 5, 0, 'h24);
    m_mem[6] = enc_r(1, 5, 4, 0, 'h23);
    m_mem[7] = enc_i('h08, 0, 0, 16'd5);
    m_mem[8] = enc_r(0, 0, 12, 0, 'h21);
    load_and_run(20);
    dbg_chk(1, 32'd13, "R3 r1");
    dbg_chk(3, 32'd1, "R3 sltiu r3");
    dbg_chk(4, 32'd12, "R2 r4");
    dbg_chk(5, 32'd1, "R2 r5");
    dbg_chk(0, 32'd0, "R7 r0 after write");
    // program B: backward beq loop
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_mem[0] = enc_i('h08, 0, 6, 16'hFFFE);
    m_mem[1] = enc_i('h08, 0, 7, 16'd5);
    m_mem[2] = enc_r(6, 7, 8, 0, 'h25);
    m_mem[3] = enc_i('h08, 0, 9, 16'hFFFF);
    m_mem[4] = enc_i('h08, 6, 6, 16'd2);
    m_mem[5] = enc_r(9, 6, 9, 0, 'h21);
    m_mem[6] = enc_i('h04, 6, 0, 16'hFFFD);
    load_and_run(20);
    dbg_chk(6, 32'd2, "R6 r6");
    dbg_chk(8, 32'hFFFFFFFF, "R2 r8");
    dbg_chk(9, 32'd1, "R6 r9");
    // program C: upper immediate and arithmetic shift loop
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_mem[0] = enc_i('h0D, 0, 10, 16'd3);
    m_mem[1] = enc_i('h0F, 0, 11, 16'hFFF6);
    m_mem[2] = enc_r(9, 11, 11, 8, 'h03);
    m_mem[3] = enc_r(10, 11, 11, 0, 'h07);
    m_mem[4] = enc_i('h08, 10, 10, 16'hFFFF);
    m_mem[5] = enc_i('h05, 10, 0, 16'hFFFD);
    load_and_run(24);
    dbg_chk(10, 32'd0, "R4 r10");
    dbg_chk(11, 32'hFFFFFFD8, "R5 r11");
    // random programs, half with load beats offered while running
    for (int p = 0; p < 30; p++) begin
      for (int i = 0; i < 64; i++) m_mem[i] = rnd_ins();
      junk_on = (p % 2) == 1;
      load_and_run(60);
      junk_on = 0;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule